// File: doc/BRIEF.md
# Big-Endian Word Memory Port Controller

This block sits between a processor core and a simple byte-addressed memory bus. The core asks for one 32-bit word at a time, either a read or a write. It uses a valid/ready request handshake and gets a one-cycle done pulse back. On the bus side the controller drives an address bus and a narrow write-data bus. It raises either a read strobe or a write strobe, and then waits for the memory to answer on a separate completion line. The memory may take any number of cycles to answer.

The bus data path is a parameter, one byte wide by default. A word access therefore becomes a run of beats at consecutive byte addresses starting at the requested address. The byte at the lowest address is the most significant byte of the word. Reads shift each returned byte in from the bottom, so the first byte ends up on top. Writes send the top byte of the word first. Before each beat the address is set up for one cycle with no strobe raised. The strobe then stays up, with address and data held, until completion is sampled. The strobe drops in the next cycle.

Top module: `be_mem_port`

## Requirements
- R1: While reset is applied and after it is released, the block is idle: `req_ready` is 1, `busy` is 0, `rsp_done` is 0, and both `bus_rd` and `bus_wr` are 0.
- R2: In every beat, `bus_addr` carries the beat's address for at least one cycle with both strobes low before the strobe rises, and it does not change on the cycle the strobe rises.
- R3: While a strobe is high and `bus_complete` has not been sampled high, `bus_addr`, `bus_wdata` and both strobes keep their values from one cycle to the next.
- R4: In the cycle after a clock edge that sampled `bus_complete` high while a strobe was high, both strobes are low.
- R5: `bus_rd` and `bus_wr` are never high in the same cycle.
- R6: A word read at byte address x issues beats at x, x+1, x+2 and x+3, in that order. The result in `rsp_rdata` is {byte(x), byte(x+1), byte(x+2), byte(x+3)}, with byte(x) in bits 31:24. Alignment is not required.
- R7: A word write at byte address x drives bits 31:24 of `req_wdata` on `bus_wdata` in the beat at x, bits 23:16 at x+1, bits 15:8 at x+2, and bits 7:0 at x+3.
- R8: Read data is captured from `bus_rdata` on the clock edge that samples `bus_complete` high. The bus value at any other edge does not affect the result.
- R9: `req_ready` is 1 only while the block is idle. A request is taken on an edge where both `req_valid` and `req_ready` are 1. A request presented while busy is not acted on and issues no strobe until the block returns to idle and takes it.
- R10: `rsp_done` is high for exactly one cycle, directly after the edge that sampled completion of the final beat. `rsp_rdata` holds the read word during that cycle. In the following cycle the block is idle again.
- R11: Results and beat order do not depend on how many cycles the memory waits before raising completion, including zero wait cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Block can take a request (idle) |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Word to write |
| rsp_done | output | 1 | One-cycle pulse when the access has finished |
| rsp_rdata | output | 32 | Read word, valid while rsp_done is high after a read |
| busy | output | 1 | An access is in progress |
| bus_addr | output | 32 | Byte address of the current beat |
| bus_wdata | output | 8 | Byte driven for a write beat |
| bus_rdata | input | 8 | Byte returned by memory on a read beat |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_complete | input | 1 | Memory finished the current beat |

## Verification
The bound checker checks the bus protocol rules on every clock cycle. These are the rules that relate neighbouring cycles: the two strobes are exclusive, the address is set up before a strobe rises, address, data and strobe are held while completion is awaited, the strobe drops right after completion, ready is only offered when idle, and the done pulse lasts one cycle. Other properties depend on whole transactions and on what the memory holds, so only the bench's scenarios can show them. These are the big-endian packing of read words, the most-significant-first ordering of write bytes, capture of read data on the one edge where it is valid, correct results under zero, long and per-beat varying wait times, and a request that waits behind a busy block and is carried out intact once the block becomes free.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  // Transaction sequencer states
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CMD   = 2'd2,
    ST_DONE  = 2'd3
  } mpc_state_e;

endpackage

// File: rtl/mpc_rst_sync.sv
module mpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mpc_seq.sv
module mpc_seq
  import mpc_pkg::*;
#(
  parameter int BEATS = 4,
  localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       complete,
  output mpc_state_e state,
  output logic       step
);

  mpc_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic last_beat;

  assign last_beat = (cnt_q == CNT_W'(BEATS - 1));
  assign step      = (st_q == ST_CMD) && complete;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d   = ST_SETUP;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_SETUP: begin
        st_d = ST_CMD;
      end
      ST_CMD: begin
        if (complete) begin
          if (last_beat) begin
            st_d = ST_DONE;
          end else begin
            st_d   = ST_SETUP;
            cnt_d  = cnt_q + CNT_W'(1);
            cnt_en = 1'b1;
          end
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/mpc_lane_shift.sv
module mpc_lane_shift #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BUS_W  = 8,
  localparam int BEATS = WORD_W / BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              is_read,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [WORD_W-1:0] load_data,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic [ADDR_W-1:0] addr_out,
  output logic [WORD_W-1:0] word_out,
  output logic [BUS_W-1:0]  lane_out
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [WORD_W-1:0] shifted;
  logic              upd_en;

  // Most significant lane leaves first on writes; read lanes enter at the bottom
  generate
    if (BEATS == 1) begin : g_single
      assign shifted = is_read ? bus_rdata : data_q;
    end else begin : g_multi
      assign shifted = {data_q[WORD_W-BUS_W-1:0],
                        (is_read ? bus_rdata : {BUS_W{1'b0}})};
    end
  endgenerate

  assign upd_en = load | step;

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (load) begin
      addr_d = load_addr;
      data_d = load_data;
    end else if (step) begin
      addr_d = addr_q + ADDR_W'(1);
      data_d = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign addr_out = addr_q;
  assign word_out = data_q;
  assign lane_out = data_q[WORD_W-1 -: BUS_W];

endmodule

// File: rtl/be_mem_port.sv
module be_mem_port
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int BUS_W  = 8,
  localparam int BEATS = WORD_W / BUS_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rd,
  output logic              bus_wr,
  input  logic              bus_complete
);

  logic       rst_n;
  logic       start;
  logic       step;
  logic       wr_q;
  mpc_state_e state;

  mpc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .rst_n_sync (rst_n)
  );

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= 1'b0;
    end else if (start) begin
      wr_q <= req_write;
    end
  end

  mpc_seq #(.BEATS(BEATS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .complete (bus_complete),
    .state    (state),
    .step     (step)
  );

  mpc_lane_shift #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .BUS_W  (BUS_W)
  ) u_lane (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .step      (step),
    .is_read   (!wr_q),
    .load_addr (req_addr),
    .load_data (req_wdata),
    .bus_rdata (bus_rdata),
    .addr_out  (bus_addr),
    .word_out  (rsp_rdata),
    .lane_out  (bus_wdata)
  );

  assign bus_rd   = (state == ST_CMD) && !wr_q;
  assign bus_wr   = (state == ST_CMD) &&  wr_q;
  assign rsp_done = (state == ST_DONE);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/mpc_checker.sv
module mpc_checker #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_complete
);

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !(bus_rd && bus_wr));

  p_addr_setup_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bus_rd && !$past(bus_rd)) || (bus_wr && !$past(bus_wr)))
      |-> ($stable(bus_addr) && !$past(bus_rd) && !$past(bus_wr)));

  p_hold_wait_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bus_rd || bus_wr) && !bus_complete)
      |=> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_rd) && $stable(bus_wr)));

  p_drop_after_cpl_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    ((bus_rd || bus_wr) && bus_complete) |=> (!bus_rd && !bus_wr));

  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> !busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_done |=> (!rsp_done && req_ready));

endmodule

bind be_mem_port mpc_checker #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .req_ready    (req_ready),
  .busy         (busy),
  .rsp_done     (rsp_done),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .bus_rd       (bus_rd),
  .bus_wr       (bus_wr),
  .bus_complete (bus_complete)
);

// File: tb/sim_be_mem_port.sv
`timescale 1ns/1ps
module sim_be_mem_port;

  logic        clk;
  logic        rst_ni;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        busy;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic        bus_rd;
  logic        bus_wr;
  logic        bus_complete;

  be_mem_port u0 (
    .clk          (clk),
    .rst_ni       (rst_ni),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .rsp_done     (rsp_done),
    .rsp_rdata    (rsp_rdata),
    .busy         (busy),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_complete (bus_complete)
  );

  // 200 MHz
  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // ---------------- byte-array memory with variable wait ----------------
  logic [7:0] mem [0:255];
  int base_lat  = 0;
  bit vary_lat  = 1'b0;

  function automatic logic [31:0] be_word(input logic [31:0] a);
    return {mem[a[7:0]], mem[8'(a[7:0] + 8'd1)], mem[8'(a[7:0] + 8'd2)], mem[8'(a[7:0] + 8'd3)]};
  endfunction

  initial begin
    int wait_cnt;
    int lat_now;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    bus_complete = 1'b0;
    bus_rdata    = 8'hEE;
    wait_cnt     = 0;
    forever begin
      @(negedge clk);
      if (bus_complete) begin
        if (!bus_rd && !bus_wr) begin
          bus_complete = 1'b0;
          bus_rdata    = 8'hEE;
        end
      end else if (bus_rd || bus_wr) begin
        lat_now = base_lat + (vary_lat ? int'(bus_addr[1:0]) * 2 : 0);
        if (wait_cnt >= lat_now) begin
          bus_complete = 1'b1;
          if (bus_rd) bus_rdata = mem[bus_addr[7:0]];
          else        mem[bus_addr[7:0]] = bus_wdata;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end
    end
  end

  // ---------------- bus monitor, samples mid-cycle ----------------
  logic [31:0] alog [0:63];
  logic [7:0]  dlog [0:63];
  int log_n = 0;
  int v_r2 = 0, v_r3 = 0, v_r4 = 0, v_r5 = 0;

  initial begin
    logic        p_rd, p_wr, p_cpl;
    logic [31:0] p_addr;
    logic [7:0]  p_wdata;
    p_rd = 1'b0; p_wr = 1'b0; p_cpl = 1'b0; p_addr = '0; p_wdata = '0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_ni) begin
        if (bus_rd && bus_wr) v_r5++;
        if ((bus_rd || bus_wr) && !(p_rd || p_wr)) begin
          if (bus_addr != p_addr) v_r2++;
          if (log_n < 64) begin
            alog[log_n] = bus_addr;
            dlog[log_n] = bus_wdata;
            log_n++;
          end
        end
        if ((p_rd || p_wr) && !p_cpl &&
            !(bus_rd == p_rd && bus_wr == p_wr && bus_addr == p_addr && bus_wdata == p_wdata)) v_r3++;
        if ((p_rd || p_wr) && p_cpl && (bus_rd || bus_wr)) v_r4++;
      end
      p_rd = bus_rd; p_wr = bus_wr; p_cpl = bus_complete;
      p_addr = bus_addr; p_wdata = bus_wdata;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // ---------------- request driver ----------------
  bit done_then_idle;

  task automatic do_req(input logic w, input logic [31:0] a, input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    r = rsp_rdata;
    @(negedge clk);
    done_then_idle = !rsp_done && req_ready && !busy;
  endtask

  task automatic t_reset;
    chk(req_ready && !busy && !rsp_done && !bus_rd && !bus_wr, "R1 idle after reset",
        {27'd0, req_ready, busy, rsp_done, bus_rd, bus_wr}, 32'h10);
  endtask

  task automatic t_read(input logic [31:0] a, input int lat, input bit vary, input string tag);
    logic [31:0] exp, got;
    int base;
    bit order_ok;
    base_lat = lat; vary_lat = vary;
    exp  = be_word(a);
    base = log_n;
    do_req(1'b0, a, 32'h0, got);
    chk(got == exp, {tag, " R6 R8 big-endian read word"}, got, exp);
    order_ok = (log_n - base == 4);
    for (int i = 0; i < 4; i++) if (order_ok && alog[base + i] != a + 32'(i)) order_ok = 1'b0;
    chk(order_ok, {tag, " R6 beat addresses x..x+3"}, 32'(log_n - base), 32'd4);
    chk(done_then_idle, {tag, " R10 one-cycle done then idle"}, {31'd0, done_then_idle}, 32'd1);
  endtask

  task automatic t_write(input logic [31:0] a, input logic [31:0] d, input int lat);
    logic [31:0] got, back;
    int base;
    bit order_ok;
    base_lat = lat; vary_lat = 1'b0;
    base = log_n;
    do_req(1'b1, a, d, got);
    chk(be_word(a) == d, "R7 bytes stored big-endian", be_word(a), d);
    order_ok = (log_n - base == 4);
    for (int i = 0; i < 4; i++)
      if (order_ok && (alog[base + i] != a + 32'(i) || dlog[base + i] != d[31 - 8*i -: 8])) order_ok = 1'b0;
    chk(order_ok, "R7 most significant byte sent first", 32'(log_n - base), 32'd4);
    do_req(1'b0, a, 32'h0, back);
    chk(back == d, "R6 R7 read back written word", back, d);
  endtask

  task automatic t_hold_off;
    logic [31:0] exp_rd, got;
    bit ready_seen, early_wr;
    base_lat = 2; vary_lat = 1'b0;
    exp_rd = be_word(32'h30);
    ready_seen = 1'b0; early_wr = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h30; req_wdata = '0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    // read taken; present a write that must wait
    req_write = 1'b1; req_addr = 32'h50; req_wdata = 32'h5566_7788;
    while (!rsp_done) begin
      if (req_ready) ready_seen = 1'b1;
      if (bus_wr) early_wr = 1'b1;
      @(negedge clk);
    end
    got = rsp_rdata;
    if (req_ready) ready_seen = 1'b1;
    chk(got == exp_rd, "R9 first read intact", got, exp_rd);
    chk(!ready_seen, "R9 ready low while busy", {31'd0, ready_seen}, 32'd0);
    chk(!early_wr, "R9 held request issued no strobe", {31'd0, early_wr}, 32'd0);
    chk(be_word(32'h50) != 32'h5566_7788, "R9 memory untouched before take", be_word(32'h50), 32'h0);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_done) @(negedge clk);
    @(negedge clk);
    chk(be_word(32'h50) == 32'h5566_7788, "R9 held write carried out", be_word(32'h50), 32'h5566_7788);
  endtask

  task automatic t_protocol;
    chk(v_r2 == 0, "R2 address set up before strobe", 32'(v_r2), 32'd0);
    chk(v_r3 == 0, "R3 bus held while waiting", 32'(v_r3), 32'd0);
    chk(v_r4 == 0, "R4 strobe dropped after completion", 32'(v_r4), 32'd0);
    chk(v_r5 == 0, "R5 strobes exclusive", 32'(v_r5), 32'd0);
  endtask

  initial begin
    logic [31:0] unused;
    rst_ni = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read(32'h10, 1, 1'b0, "aligned");
    t_read(32'h23, 0, 1'b0, "R11 zero-wait unaligned");
    t_read(32'h81, 5, 1'b1, "R11 long varying wait");
    t_write(32'h40, 32'hA1B2_C3D4, 0);
    t_write(32'h67, 32'h0F1E_2D3C, 3);
    t_hold_off();
    do_req(1'b0, 32'h00, 32'h0, unused);
    chk(unused == be_word(32'h00), "R6 address zero", unused, be_word(32'h00));
    t_protocol();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule